// File: doc/BRIEF.md
# Indexed Display-Mode Register Controller

This block is the configuration register file for a graphics mode. A host reaches it through two 16-bit ports that share one write strobe and one read bus: a selector port that holds a register number, and a value port that reads or writes the register that number names. The block holds a revision word, the horizontal and vertical resolution, the colour depth, the mode flags, the bank select, the virtual width and height and the two scroll offsets. All of these drive a downstream display engine directly.

Every value-port write is checked against the mode rules. An illegal write is dropped, the register keeps its old value and a one-cycle error pulse follows. The geometry registers are frozen while the mode is on. When the mode turns on, the virtual width is loaded from the horizontal resolution. A multi-cycle divider then recomputes the virtual height, so that a frame of virtual width by height pixels fits in the video memory. The same recomputation follows every write of a new virtual width.

Top module: `gmode_ctrl`

## Requirements
- R1: After a synchronous reset the outputs read hres 640, vres 480, bpp 8, mode_on 0, linear_fb 0, keep_mem 0, bank 0, virt_w 0, virt_h 0, x_off 0, y_off 0, with no error or clear pulse, and register 0 reads 0xB0C2.
- R2: A write with host_port_idx=1 stores a 16-bit register number, which host_rdata shows while host_port_idx=1. With host_port_idx=0, reads and writes reach the register that number names: 0 revision, 1 hres, 2 vres, 3 bpp, 4 flags, 5 bank, 6 virt_w, 7 virt_h, 8 x_off, 9 y_off.
- R3: Register 0 accepts only 0xB0C0, 0xB0C1 and 0xB0C2 and reads back the last accepted word. Any other value is an error.
- R4: Writing hres above 1024, or vres above 768, is an error. The limit values themselves are accepted.
- R5: The bpp values 8, 15, 16, 24 and 32 are accepted, and a written 0 is stored as 8. Any other value, 4 included, is an error.
- R6: While mode_on is 1, writes to hres, vres or bpp are errors and leave the values unchanged.
- R7: Register 4 keeps bit 0 (mode on), bit 6 (linear frame buffer) and bit 7 (keep memory) and reads every other bit as 0. It drives mode_on, linear_fb and keep_mem. Writing 0 turns the mode off.
- R8: A flags write that takes mode_on from 0 to 1 loads virt_w with hres. In the cycle after that write it raises clr_mem_pulse for one cycle, unless bit 7 is set in that write. A write while the mode is already on gives no pulse.
- R9: A written virt_w below hres is raised to hres, a 0 becomes 1, and a width beyond the memory capacity is lowered to that capacity. Such writes are not errors, and they are accepted whether the mode is on or off.
- R10: Within 32 cycles after virt_w changes, virt_h equals floor(2^22 / (virt_w * B)), saturated at 65535. B is 1 for 8 bpp, 2 for 15 and 16 bpp, 3 for 24 bpp and 4 for 32 bpp.
- R11: virt_h is read-only: a write to register 7 is an error and leaves it unchanged.
- R12: Register numbers 10 and above read as 0, and writes to them are errors.
- R13: bank, x_off and y_off accept any 16-bit value and read it back.
- R14: Each illegal value-port write gives exactly one err_pulse cycle, the cycle after the write. A legal write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_port_idx | input | 1 | 1 selects the register-number port, 0 the value port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected port |
| err_pulse | output | 1 | One-cycle pulse after an illegal write |
| clr_mem_pulse | output | 1 | One-cycle request to clear video memory |
| mode_on | output | 1 | Graphics mode enabled |
| linear_fb | output | 1 | Linear frame buffer use selected |
| keep_mem | output | 1 | Keep-memory flag |
| hres | output | 16 | Horizontal resolution |
| vres | output | 16 | Vertical resolution |
| bpp | output | 16 | Bits per pixel |
| bank | output | 16 | Bank select |
| virt_w | output | 16 | Virtual width in pixels |
| virt_h | output | 16 | Virtual height in lines |
| x_off | output | 16 | Horizontal scroll offset |
| y_off | output | 16 | Vertical scroll offset |

## Verification
The hardest conditions to reach are the ones that depend on earlier history. These are the lock of the geometry registers, the clear pulse that is suppressed by the keep bit in the same write, and the saturation of the virtual height. The bench first steps through a table of single writes on a disabled mode. It then builds the needed history in order. It sets a 10-pixel resolution, so that a 20-pixel virtual width overflows the 16-bit height. It turns the mode on, with and without the keep bit, and retries geometry writes while the mode is on. It waits out the divider before each height is compared.

// File: rtl/gmode_pkg.sv
`timescale 1ns/1ps
package gmode_pkg;

    localparam int unsigned DW       = 16;
    localparam int unsigned NUM_REGS = 10;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [3:0] {
        RS_ID   = 4'd0,
        RS_HRES = 4'd1,
        RS_VRES = 4'd2,
        RS_BPP  = 4'd3,
        RS_FLAG = 4'd4,
        RS_BANK = 4'd5,
        RS_VW   = 4'd6,
        RS_VH   = 4'd7,
        RS_XO   = 4'd8,
        RS_YO   = 4'd9,
        RS_NONE = 4'd15
    } reg_sel_e;

    localparam word_t REV_A = 16'hB0C0;
    localparam word_t REV_B = 16'hB0C1;
    localparam word_t REV_C = 16'hB0C2;

    localparam int unsigned ON_BIT   = 0;
    localparam int unsigned LIN_BIT  = 6;
    localparam int unsigned KEEP_BIT = 7;

    typedef struct packed {
        word_t ident;
        word_t hres;
        word_t vres;
        word_t bpp;
        logic  on;
        logic  linear;
        logic  keep;
        word_t bank;
        word_t vw;
        word_t vh;
        word_t xo;
        word_t yo;
    } mode_cfg_t;

    function automatic logic bpp_ok(word_t v);
        return (v == 16'd0) || (v == 16'd8) || (v == 16'd15) ||
               (v == 16'd16) || (v == 16'd24) || (v == 16'd32);
    endfunction

    function automatic logic [2:0] bytes_of(word_t bits);
        logic [2:0] b;
        case (bits)
            16'd15, 16'd16: b = 3'd2;
            16'd24:         b = 3'd3;
            16'd32:         b = 3'd4;
            default:        b = 3'd1;
        endcase
        return b;
    endfunction

    // Widest line that still leaves one full line in memory, clipped to a word
    function automatic word_t width_cap(int unsigned mem_log2, logic [2:0] bpb);
        logic [63:0] total;
        logic [63:0] per;
        total = 64'd1 << mem_log2;
        case (bpb)
            3'd2:    per = total >> 1;
            3'd3:    per = total / 64'd3;
            3'd4:    per = total >> 2;
            default: per = total;
        endcase
        return (per > 64'hFFFF) ? 16'hFFFF : per[DW-1:0];
    endfunction

    function automatic word_t flag_word(mode_cfg_t c);
        word_t w;
        w = '0;
        w[ON_BIT]   = c.on;
        w[LIN_BIT]  = c.linear;
        w[KEEP_BIT] = c.keep;
        return w;
    endfunction

endpackage

// File: rtl/gmode_host_port.sv
`timescale 1ns/1ps
module gmode_host_port
    import gmode_pkg::*;
#(
    parameter int unsigned NREG = NUM_REGS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic      port_idx,
    input  word_t     wdata,
    input  mode_cfg_t cfg,
    output logic      data_wr,
    output reg_sel_e  sel,
    output word_t     rdata
);

    word_t idx_q;
    word_t reg_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (wr && port_idx) begin
            idx_q <= wdata;
        end
    end

    assign data_wr = wr && !port_idx;

    always_comb begin
        if (idx_q < word_t'(NREG)) begin
            sel = reg_sel_e'(idx_q[3:0]);
        end else begin
            sel = RS_NONE;
        end
    end

    always_comb begin
        case (sel)
            RS_ID:   reg_val = cfg.ident;
            RS_HRES: reg_val = cfg.hres;
            RS_VRES: reg_val = cfg.vres;
            RS_BPP:  reg_val = cfg.bpp;
            RS_FLAG: reg_val = flag_word(cfg);
            RS_BANK: reg_val = cfg.bank;
            RS_VW:   reg_val = cfg.vw;
            RS_VH:   reg_val = cfg.vh;
            RS_XO:   reg_val = cfg.xo;
            RS_YO:   reg_val = cfg.yo;
            default: reg_val = '0;
        endcase
    end

    assign rdata = port_idx ? idx_q : reg_val;

    // R2: the register number only moves on a selector-port write
    a_r2_idx_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr && port_idx) |=> $stable(idx_q));

endmodule

// File: rtl/gmode_wr_check.sv
`timescale 1ns/1ps
module gmode_wr_check
    import gmode_pkg::*;
#(
    parameter int unsigned MAX_HRES = 1024,
    parameter int unsigned MAX_VRES = 768,
    parameter int unsigned MEM_LOG2 = 22
) (
    input  reg_sel_e sel,
    input  word_t    wdata,
    input  logic     on,
    input  word_t    hres,
    input  word_t    bpp,
    output logic     legal,
    output word_t    nval,
    output word_t    hres_fit
);

    word_t cap;

    function automatic word_t fit_w(word_t w, word_t floor_w, word_t lim);
        word_t r;
        r = (w < floor_w) ? floor_w : w;
        if (r == '0) r = 16'd1;
        if (r > lim) r = lim;
        return r;
    endfunction

    assign cap      = width_cap(MEM_LOG2, bytes_of(bpp));
    assign hres_fit = fit_w(hres, hres, cap);

    always_comb begin
        legal = 1'b1;
        nval  = wdata;
        case (sel)
            RS_ID:   legal = (wdata == REV_A) || (wdata == REV_B) || (wdata == REV_C);
            RS_HRES: legal = !on && (wdata <= word_t'(MAX_HRES));
            RS_VRES: legal = !on && (wdata <= word_t'(MAX_VRES));
            RS_BPP: begin
                legal = !on && bpp_ok(wdata);
                nval  = (wdata == '0) ? 16'd8 : wdata;
            end
            RS_FLAG: begin
                nval           = '0;
                nval[ON_BIT]   = wdata[ON_BIT];
                nval[LIN_BIT]  = wdata[LIN_BIT];
                nval[KEEP_BIT] = wdata[KEEP_BIT];
            end
            RS_VW:   nval  = fit_w(wdata, hres, cap);
            RS_BANK, RS_XO, RS_YO: legal = 1'b1;
            default: legal = 1'b0;
        endcase
    end

    // R9: an adjusted width never falls to zero
    always_comb begin
        if (sel == RS_VW) a_r9_width_nonzero: assert (nval != '0);
    end

endmodule

// File: rtl/gmode_height_div.sv
`timescale 1ns/1ps
module gmode_height_div
    import gmode_pkg::*;
#(
    parameter int unsigned MEM_LOG2 = 22,
    parameter int unsigned WW       = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [WW-1:0] width,
    input  logic [2:0]    bpb,
    output logic          done,
    output logic [WW-1:0] height
);

    localparam int unsigned QW = MEM_LOG2 + 1;
    localparam int unsigned VB = WW + 3;
    localparam int unsigned CW = $clog2(QW + 1);

    logic [VB-1:0] dvs;
    logic [VB-1:0] rem;
    logic [QW-1:0] quo;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [VB:0]   trial;
    logic          ge;
    logic [VB-1:0] rem_n;

    always_comb begin
        trial = {rem, quo[QW-1]};
        ge    = trial >= {1'b0, dvs};
        rem_n = ge ? VB'(trial - {1'b0, dvs}) : trial[VB-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvs  <= '0;
            rem  <= '0;
            quo  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                dvs  <= VB'(width) * VB'(bpb);
                rem  <= '0;
                quo  <= QW'(1) << MEM_LOG2;
                cnt  <= CW'(QW);
                busy <= 1'b1;
            end else if (busy) begin
                rem <= rem_n;
                quo <= {quo[QW-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    generate
        if (QW > WW) begin : g_sat
            assign height = (|quo[QW-1:WW]) ? '1 : quo[WW-1:0];
        end else begin : g_wide
            assign height = WW'(quo);
        end
    endgenerate

    // R10: a result is only announced at the end of a running division
    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(QW));

endmodule

// File: rtl/gmode_ctrl.sv
`timescale 1ns/1ps
module gmode_ctrl
    import gmode_pkg::*;
#(
    parameter int unsigned MAX_HRES = 1024,
    parameter int unsigned MAX_VRES = 768,
    parameter int unsigned MEM_LOG2 = 22,
    parameter int unsigned RST_HRES = 640,
    parameter int unsigned RST_VRES = 480,
    parameter int unsigned RST_BPP  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_port_idx,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        err_pulse,
    output logic        clr_mem_pulse,
    output logic        mode_on,
    output logic        linear_fb,
    output logic        keep_mem,
    output logic [15:0] hres,
    output logic [15:0] vres,
    output logic [15:0] bpp,
    output logic [15:0] bank,
    output logic [15:0] virt_w,
    output logic [15:0] virt_h,
    output logic [15:0] x_off,
    output logic [15:0] y_off
);

    localparam mode_cfg_t RST_CFG = '{
        ident:  REV_C,
        hres:   word_t'(RST_HRES),
        vres:   word_t'(RST_VRES),
        bpp:    word_t'(RST_BPP),
        on:     1'b0,
        linear: 1'b0,
        keep:   1'b0,
        bank:   '0,
        vw:     '0,
        vh:     '0,
        xo:     '0,
        yo:     '0
    };

    mode_cfg_t cfg;
    logic      data_wr;
    reg_sel_e  sel;
    logic      legal;
    word_t     nval;
    word_t     hres_fit;
    logic      rising;
    logic      div_start;
    word_t     div_w;
    logic      div_done;
    word_t     div_h;
    logic      err_q;
    logic      clr_q;

    gmode_host_port #(.NREG(NUM_REGS)) u_port (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_wr),
        .port_idx (host_port_idx),
        .wdata    (host_wdata),
        .cfg      (cfg),
        .data_wr  (data_wr),
        .sel      (sel),
        .rdata    (host_rdata)
    );

    gmode_wr_check #(
        .MAX_HRES (MAX_HRES),
        .MAX_VRES (MAX_VRES),
        .MEM_LOG2 (MEM_LOG2)
    ) u_check (
        .sel      (sel),
        .wdata    (host_wdata),
        .on       (cfg.on),
        .hres     (cfg.hres),
        .bpp      (cfg.bpp),
        .legal    (legal),
        .nval     (nval),
        .hres_fit (hres_fit)
    );

    assign rising    = data_wr && legal && (sel == RS_FLAG) && nval[ON_BIT] && !cfg.on;
    assign div_start = (data_wr && legal && (sel == RS_VW)) || rising;
    assign div_w     = rising ? hres_fit : nval;

    gmode_height_div #(
        .MEM_LOG2 (MEM_LOG2),
        .WW       (DW)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .start  (div_start),
        .width  (div_w),
        .bpb    (bytes_of(cfg.bpp)),
        .done   (div_done),
        .height (div_h)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= RST_CFG;
            err_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            err_q <= data_wr && !legal;
            clr_q <= 1'b0;
            if (div_done) cfg.vh <= div_h;
            if (data_wr && legal) begin
                case (sel)
                    RS_ID:   cfg.ident <= nval;
                    RS_HRES: cfg.hres  <= nval;
                    RS_VRES: cfg.vres  <= nval;
                    RS_BPP:  cfg.bpp   <= nval;
                    RS_FLAG: begin
                        cfg.on     <= nval[ON_BIT];
                        cfg.linear <= nval[LIN_BIT];
                        cfg.keep   <= nval[KEEP_BIT];
                        if (rising) begin
                            cfg.vw <= hres_fit;
                            clr_q  <= !nval[KEEP_BIT];
                        end
                    end
                    RS_BANK: cfg.bank <= nval;
                    RS_VW:   cfg.vw   <= nval;
                    RS_XO:   cfg.xo   <= nval;
                    RS_YO:   cfg.yo   <= nval;
                    default: ;
                endcase
            end
        end
    end

    assign err_pulse     = err_q;
    assign clr_mem_pulse = clr_q;
    assign mode_on       = cfg.on;
    assign linear_fb     = cfg.linear;
    assign keep_mem      = cfg.keep;
    assign hres          = cfg.hres;
    assign vres          = cfg.vres;
    assign bpp           = cfg.bpp;
    assign bank          = cfg.bank;
    assign virt_w        = cfg.vw;
    assign virt_h        = cfg.vh;
    assign x_off         = cfg.xo;
    assign y_off         = cfg.yo;

    a_r4_hres_cap: assert property (@(posedge clk) disable iff (rst)
        hres <= 16'(MAX_HRES));

    a_r4_vres_cap: assert property (@(posedge clk) disable iff (rst)
        vres <= 16'(MAX_VRES));

    a_r5_bpp_set: assert property (@(posedge clk) disable iff (rst)
        (bpp == 16'd8) || (bpp == 16'd15) || (bpp == 16'd16) ||
        (bpp == 16'd24) || (bpp == 16'd32));

    a_r6_geom_locked: assert property (@(posedge clk) disable iff (rst)
        (mode_on && $past(mode_on)) |-> ($stable(hres) && $stable(vres) && $stable(bpp)));

    a_r8_clr_on_rise: assert property (@(posedge clk) disable iff (rst)
        clr_mem_pulse |-> (mode_on && !$past(mode_on)));

    a_r14_err_from_write: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> ($past(host_wr) && !$past(host_port_idx)));

endmodule

// File: tb/tb_gmode_ctrl.sv
`timescale 1ns/1ps
module tb_gmode_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_port_idx = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        err_pulse, clr_mem_pulse, mode_on, linear_fb, keep_mem;
    logic [15:0] hres, vres, bpp, bank, virt_w, virt_h, x_off, y_off;

    int   n_chk = 0;
    int   n_bad = 0;
    logic finished = 1'b0;
    logic last_err, last_clr;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    gmode_ctrl dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_port_idx(host_port_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .err_pulse(err_pulse),
        .clr_mem_pulse(clr_mem_pulse), .mode_on(mode_on), .linear_fb(linear_fb),
        .keep_mem(keep_mem), .hres(hres), .vres(vres), .bpp(bpp), .bank(bank),
        .virt_w(virt_w), .virt_h(virt_h), .x_off(x_off), .y_off(y_off)
    );

    // {tag[3:0], reg[3:0], value[15:0], expect_err, expect_readback[15:0]}
    localparam int NV = 22;
    localparam logic [40:0] VEC [NV] = '{
        {4'd3,  4'd0,  16'hB0C0, 1'b0, 16'hB0C0},   // R3 accepted revision
        {4'd3,  4'd0,  16'h1234, 1'b1, 16'hB0C0},   // R3 unknown revision
        {4'd3,  4'd0,  16'hB0C1, 1'b0, 16'hB0C1},   // R3
        {4'd4,  4'd1,  16'd1025, 1'b1, 16'd640},    // R4 above limit
        {4'd4,  4'd1,  16'd1024, 1'b0, 16'd1024},   // R4 at limit
        {4'd4,  4'd2,  16'd769,  1'b1, 16'd480},    // R4
        {4'd4,  4'd2,  16'd768,  1'b0, 16'd768},    // R4
        {4'd5,  4'd3,  16'd4,    1'b1, 16'd8},      // R5 depth 4 refused
        {4'd5,  4'd3,  16'd16,   1'b0, 16'd16},     // R5
        {4'd5,  4'd3,  16'd0,    1'b0, 16'd8},      // R5 zero means 8
        {4'd5,  4'd3,  16'd15,   1'b0, 16'd15},     // R5
        {4'd5,  4'd3,  16'd24,   1'b0, 16'd24},     // R5
        {4'd5,  4'd3,  16'd33,   1'b1, 16'd24},     // R5
        {4'd5,  4'd3,  16'd32,   1'b0, 16'd32},     // R5
        {4'd13, 4'd5,  16'h003F, 1'b0, 16'h003F},   // R13 bank
        {4'd13, 4'd8,  16'h1234, 1'b0, 16'h1234},   // R13 x offset
        {4'd13, 4'd9,  16'hFFFF, 1'b0, 16'hFFFF},   // R13 y offset
        {4'd11, 4'd7,  16'd5,    1'b1, 16'd0},      // R11 read-only height
        {4'd12, 4'd12, 16'd1,    1'b1, 16'd0},      // R12 unused number
        {4'd12, 4'd10, 16'd7,    1'b1, 16'd0},      // R12
        {4'd9,  4'd6,  16'd100,  1'b0, 16'd1024},   // R9 raised to hres
        {4'd9,  4'd6,  16'd1500, 1'b0, 16'd1500}    // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic p, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_port_idx = p; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        last_err = err_pulse;
        last_clr = clr_mem_pulse;
        host_port_idx = 1'b0;
        #1;
    endtask

    task automatic wr_reg(input logic [15:0] r, input logic [15:0] v);
        put(1'b1, r);
        put(1'b0, v);
    endtask

    task automatic rd_reg(input logic [15:0] r, output logic [15:0] v);
        put(1'b1, r);
        v = host_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic int exp_h(input int w, input int bits);
        int b;
        int h;
        case (bits)
            8:       b = 1;
            15, 16:  b = 2;
            24:      b = 3;
            default: b = 4;
        endcase
        h = 4194304 / (w * b);
        if (h > 65535) h = 65535;
        return h;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", hres, 640, "hres after reset");
        chk("R1", vres, 480, "vres after reset");
        chk("R1", bpp, 8, "bpp after reset");
        chk("R1", {mode_on, linear_fb, keep_mem}, 0, "flags after reset");
        chk("R1", {bank, x_off, y_off}, 0, "bank/offsets after reset");
        chk("R1", {virt_w, virt_h}, 0, "virtual size after reset");
        chk("R1", {err_pulse, clr_mem_pulse}, 0, "pulses after reset");
        rd_reg(16'd0, rv);
        chk("R1", rv, 16'hB0C2, "revision after reset");

        // Table walk
        for (int k = 0; k < NV; k++) begin
            logic [40:0] v;
            v = VEC[k];
            wr_reg({12'd0, v[36:33]}, v[32:17]);
            chk($sformatf("R%0d", v[40:37]), last_err, v[16], $sformatf("error flag row %0d", k));
            if (v[16]) chk("R14", last_err, 1'b1, "illegal write pulses");
            rd_reg({12'd0, v[36:33]}, rv);
            chk($sformatf("R%0d", v[40:37]), rv, v[15:0], $sformatf("readback row %0d", k));
        end
        chk("R13", {bank, x_off, y_off}, {16'h003F, 16'h1234, 16'hFFFF}, "ports follow");

        // R10 height after width 1500 at 32 bpp
        wait_cyc(40);
        rd_reg(16'd7, rv);
        chk("R10", rv, exp_h(1500, 32), "height w1500 bpp32");

        // R2 selector readback and unused number read
        put(1'b1, 16'h0123);
        host_port_idx = 1'b1; #1;
        chk("R2", host_rdata, 16'h0123, "selector readback");
        host_port_idx = 1'b0; #1;
        chk("R12", host_rdata, 0, "unused number reads zero");

        // R10 saturation with a tiny line
        wr_reg(16'd1, 16'd10);
        wr_reg(16'd3, 16'd8);
        wr_reg(16'd6, 16'd20);
        chk("R9", virt_w, 20, "width 20 kept");
        wait_cyc(40);
        chk("R10", virt_h, 65535, "height saturates");
        wr_reg(16'd6, 16'd0);
        chk("R9", virt_w, 10, "zero width raised to hres");
        wr_reg(16'd3, 16'd24);
        wr_reg(16'd6, 16'd1800);
        wait_cyc(40);
        chk("R10", virt_h, exp_h(1800, 24), "height w1800 bpp24");

        // Enable sequence
        wr_reg(16'd1, 16'd640);
        wr_reg(16'd2, 16'd480);
        wr_reg(16'd3, 16'd16);
        wr_reg(16'd4, 16'h0041);
        chk("R8", last_clr, 1'b1, "clear pulse on enable");
        chk("R14", last_err, 1'b0, "legal write no error");
        chk("R7", {mode_on, linear_fb, keep_mem}, 3'b110, "flags after 0x41");
        chk("R8", virt_w, 640, "width loaded from hres");
        @(negedge clk); #1;
        chk("R8", clr_mem_pulse, 1'b0, "clear pulse one cycle");
        wait_cyc(40);
        chk("R10", virt_h, exp_h(640, 16), "height on enable");
        rd_reg(16'd4, rv);
        chk("R7", rv, 16'h0041, "flag readback");

        // R6 lock while enabled
        wr_reg(16'd1, 16'd800);
        chk("R6", last_err, 1'b1, "hres write locked");
        @(negedge clk); #1;
        chk("R14", err_pulse, 1'b0, "error pulse one cycle");
        chk("R6", hres, 640, "hres unchanged");
        wr_reg(16'd3, 16'd32);
        chk("R6", last_err, 1'b1, "bpp write locked");
        chk("R6", bpp, 16, "bpp unchanged");
        wr_reg(16'd2, 16'd600);
        chk("R6", last_err, 1'b1, "vres write locked");
        chk("R6", vres, 480, "vres unchanged");

        // Flags while on: no pulse
        wr_reg(16'd4, 16'h0081);
        chk("R8", last_clr, 1'b0, "no pulse when already on");
        rd_reg(16'd4, rv);
        chk("R7", rv, 16'h0081, "flag readback 0x81");
        chk("R7", linear_fb, 1'b0, "linear cleared");

        // R9 width change while on
        wr_reg(16'd6, 16'd2048);
        chk("R9", virt_w, 2048, "width write while on");
        wait_cyc(40);
        chk("R10", virt_h, exp_h(2048, 16), "height w2048 bpp16");

        // Off, then on with keep bit and stray bits
        wr_reg(16'd4, 16'h0000);
        chk("R7", mode_on, 1'b0, "mode off");
        wr_reg(16'd4, 16'h00FF);
        chk("R8", last_clr, 1'b0, "keep bit suppresses clear");
        rd_reg(16'd4, rv);
        chk("R7", rv, 16'h00C1, "stray bits dropped");
        wr_reg(16'd4, 16'h0000);
        wr_reg(16'd4, 16'h0001);
        chk("R8", last_clr, 1'b1, "clear pulse second enable");

        finished = 1'b1;
        summary();
    end

endmodule